// File: doc/BRIEF.md
# Line Loss-of-Signal Monitor with Alarm Substitution

This block watches the recovered receive pulse stream of a T1/J1 or E1 line. It gets one strobe per bit interval and decides when the line has lost signal and when it has recovered. The analog front end supplies three flags: a pulse-present flag for the current interval, a flag saying the level is under the declare threshold, and a flag saying the level is over the clear threshold. A mode bit and a criteria bit pick one of four declare windows. The mode bit alone picks the clear window, the minimum mark count and the zero-run limit.

Loss of signal is declared after a run of quiet intervals. It is cleared only after a full observation window passes all of its checks. That window opens on the first pulse received while the alarm is raised. While the alarm is active, the block also drives the select lines that replace receive data and transmit line data with all ones. Another select line switches the receive clock over to the master clock.

Top module: `los_monitor`

## Requirements
- R1: Out of reset `los` is 1 and `los_irq` is 0.
- R2: With `los` at 0, `los` rises after N consecutive qualifying strobes. N is set by {`mode_t1`,`crit_sel`}: 10 gives 175, 11 gives 1544, 00 gives 32 and 01 gives 2048.
- R3: A strobe qualifies only when `pulse_in` is 0 and `lvl_below_decl` is 1. Any other strobe restarts the count. Cycles with `bit_stb` at 0 are ignored.
- R4: With `los` at 1, a clear window opens on the first strobe that has `pulse_in` and `lvl_above_clr` both at 1. That strobe is interval 1 of the window. When the window passes, `los` falls on the window's M-th strobe, where M is 128 when `mode_t1`=1 and 32 when `mode_t1`=0.
- R5: A window passes only if it holds at least 16 pulses (T1/J1) or at least 4 pulses (E1). A window that ends short of that leaves `los` at 1, and the next pulse opens a new window.
- R6: A run of 100 zero intervals (T1/J1) or 16 zero intervals (E1) inside a window fails that window at once. A run one shorter than the limit is allowed. After a failure the next pulse opens a new window.
- R7: A window strobe with `lvl_above_clr` at 0 fails the window.
- R8: `los_irq` is a one-cycle pulse in the same cycle that `los` goes from 0 to 1. It stays 0 when `irq_mask` is 1.
- R9: `rx_force_ones` and `rx_clk_sel_mclk` are 1 exactly when `los` and `rx_ais_en` are both 1. `tx_force_ones` is 1 exactly when `los` and `line_ais_en` are both 1.
- R10: A change of `mode_t1` or `crit_sel` restarts the declare count and closes any open clear window. `los` keeps its value when this happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_stb | input | 1 | One pulse per received bit interval |
| pulse_in | input | 1 | A mark was received in this interval |
| lvl_below_decl | input | 1 | Line level is under the declare threshold |
| lvl_above_clr | input | 1 | Line level is over the clear threshold |
| mode_t1 | input | 1 | 1 = T1/J1, 0 = E1 |
| crit_sel | input | 1 | Picks the long declare window when 1 |
| irq_mask | input | 1 | Suppresses the interrupt pulse |
| rx_ais_en | input | 1 | Enables all-ones substitution on the receive side |
| line_ais_en | input | 1 | Enables all-ones substitution on the line side |
| los | output | 1 | Loss-of-signal status |
| los_irq | output | 1 | One-cycle interrupt on LOS declaration |
| rx_force_ones | output | 1 | Force receive data to all ones |
| rx_clk_sel_mclk | output | 1 | Select the master clock for the receive clock output |
| tx_force_ones | output | 1 | Force transmit line data to all ones |

## Verification
The bench builds the block with its default parameters, so the windows are the standard ones. The bench asserts the strobe on every cycle of a stimulus burst. That puts even the 2048-interval declare window and the 128-interval clear window within a few thousand cycles. The boundaries are probed one interval apart: declaration at N-1 and at N, 15 against 16 marks, and zero runs of 99 against 100 and 15 against 16.

// File: rtl/los_monitor.sv
module los_monitor #(
  parameter int N_T1_STD = 175,
  parameter int N_T1_ALT = 1544,
  parameter int N_E1_STD = 32,
  parameter int N_E1_ALT = 2048,
  parameter int M_T1     = 128,
  parameter int M_E1     = 32,
  parameter int MARKS_T1 = 16,
  parameter int MARKS_E1 = 4,
  parameter int ZRUN_T1  = 100,
  parameter int ZRUN_E1  = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_stb,
  input  logic pulse_in,
  input  logic lvl_below_decl,
  input  logic lvl_above_clr,
  input  logic mode_t1,
  input  logic crit_sel,
  input  logic irq_mask,
  input  logic rx_ais_en,
  input  logic line_ais_en,
  output logic los,
  output logic los_irq,
  output logic rx_force_ones,
  output logic rx_clk_sel_mclk,
  output logic tx_force_ones
);
  localparam int NT = (N_T1_STD > N_T1_ALT) ? N_T1_STD : N_T1_ALT;
  localparam int NE = (N_E1_STD > N_E1_ALT) ? N_E1_STD : N_E1_ALT;
  localparam int N_MAX = (NT > NE) ? NT : NE;
  localparam int M_MAX = (M_T1 > M_E1) ? M_T1 : M_E1;
  localparam int Z_MAX = (ZRUN_T1 > ZRUN_E1) ? ZRUN_T1 : ZRUN_E1;
  localparam int DW = $clog2(N_MAX + 1);
  localparam int WW = $clog2(M_MAX + 1);
  localparam int ZW = $clog2(Z_MAX + 1);

  logic [DW-1:0] dcnt, n_lim;
  logic [WW-1:0] wcnt, marks, m_lim, d_min;
  logic [ZW-1:0] zrun, z_lim;
  logic          win;
  logic [1:0]    cfg_q;

  assign n_lim = mode_t1 ? (crit_sel ? DW'(N_T1_ALT) : DW'(N_T1_STD))
                         : (crit_sel ? DW'(N_E1_ALT) : DW'(N_E1_STD));
  assign m_lim = mode_t1 ? WW'(M_T1) : WW'(M_E1);
  assign d_min = mode_t1 ? WW'(MARKS_T1) : WW'(MARKS_E1);
  assign z_lim = mode_t1 ? ZW'(ZRUN_T1) : ZW'(ZRUN_E1);

  wire [WW-1:0] wcnt_n  = wcnt + 1'b1;
  wire [WW-1:0] marks_n = marks + WW'(pulse_in);
  wire [ZW-1:0] zrun_n  = pulse_in ? '0 : zrun + 1'b1;
  wire          quiet   = !pulse_in && lvl_below_decl;
  wire          cfg_chg = {mode_t1, crit_sel} != cfg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      los     <= 1'b1;
      los_irq <= 1'b0;
      dcnt    <= '0;
      win     <= 1'b0;
      wcnt    <= '0;
      marks   <= '0;
      zrun    <= '0;
      cfg_q   <= 2'b00;
    end else begin
      cfg_q   <= {mode_t1, crit_sel};
      los_irq <= 1'b0;
      if (cfg_chg) begin
        dcnt <= '0;
        win  <= 1'b0;
      end else if (bit_stb) begin
        if (!los) begin
          win <= 1'b0;
          if (!quiet) dcnt <= '0;
          else if (dcnt == n_lim - 1'b1) begin
            dcnt    <= '0;
            los     <= 1'b1;
            los_irq <= !irq_mask;
          end else dcnt <= dcnt + 1'b1;
        end else begin
          dcnt <= '0;
          if (!win) begin
            if (pulse_in && lvl_above_clr) begin
              win   <= 1'b1;
              wcnt  <= WW'(1);
              marks <= WW'(1);
              zrun  <= '0;
            end
          end else if (!lvl_above_clr || zrun_n >= z_lim) begin
            win <= 1'b0;
          end else begin
            wcnt  <= wcnt_n;
            marks <= marks_n;
            zrun  <= zrun_n;
            if (wcnt_n == m_lim) begin
              win <= 1'b0;
              if (marks_n >= d_min) los <= 1'b0;
            end
          end
        end
      end
    end
  end

  assign rx_force_ones   = los & rx_ais_en;
  assign rx_clk_sel_mclk = los & rx_ais_en;
  assign tx_force_ones   = los & line_ais_en;
endmodule

// File: rtl/los_monitor_chk.sv
module los_monitor_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_stb,
  input logic pulse_in,
  input logic lvl_below_decl,
  input logic lvl_above_clr,
  input logic mode_t1,
  input logic crit_sel,
  input logic irq_mask,
  input logic los,
  input logic los_irq,
  input logic rx_force_ones,
  input logic rx_clk_sel_mclk,
  input logic tx_force_ones
);
  // R8
  irq_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    los_irq |-> $rose(los));
  // R8
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    los_irq |=> !los_irq);
  // R8
  irq_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(los) && !$past(irq_mask)) |-> los_irq);
  // R3
  rise_on_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(los) |-> $past(bit_stb && !pulse_in && lvl_below_decl));
  // R7
  fall_on_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(los) |-> $past(bit_stb && lvl_above_clr));
  // R9
  ais_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !los |-> !(rx_force_ones || rx_clk_sel_mclk || tx_force_ones));
  // R10
  cfg_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_t1 != $past(mode_t1) || crit_sel != $past(crit_sel)) |=> $stable(los));
endmodule

bind los_monitor los_monitor_chk chk_i (
  .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .pulse_in(pulse_in),
  .lvl_below_decl(lvl_below_decl), .lvl_above_clr(lvl_above_clr),
  .mode_t1(mode_t1), .crit_sel(crit_sel), .irq_mask(irq_mask),
  .los(los), .los_irq(los_irq), .rx_force_ones(rx_force_ones),
  .rx_clk_sel_mclk(rx_clk_sel_mclk), .tx_force_ones(tx_force_ones)
);

// File: tb/los_monitor_tb_top.sv
module los_monitor_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bit_stb = 0, pulse_in = 0, lvl_below_decl = 0, lvl_above_clr = 0;
  logic mode_t1 = 0, crit_sel = 0, irq_mask = 0, rx_ais_en = 0, line_ais_en = 0;
  logic los, los_irq, rx_force_ones, rx_clk_sel_mclk, tx_force_ones;
  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  los_monitor dut_i (.*);

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic run(int n, int period);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bit_stb  = 1'b1;
      pulse_in = (period > 0) && (i % period == 0);
    end
    @(negedge clk);
    bit_stb  = 1'b0;
    pulse_in = 1'b0;
  endtask

  task automatic set_cfg(logic m, logic c);
    @(negedge clk);
    mode_t1 = m; crit_sel = c;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic level_good();
    lvl_above_clr = 1'b1; lvl_below_decl = 1'b0;
  endtask

  task automatic level_lost();
    lvl_above_clr = 1'b0; lvl_below_decl = 1'b1;
  endtask

  task automatic go_clear_e1();
    set_cfg(0, 1); set_cfg(0, 0);
    level_good();
    run(32, 4);
  endtask

  task automatic t_reset();
    chk("R1 los after reset", los, 1'b1);
    chk("R1 irq after reset", los_irq, 1'b0);
  endtask

  task automatic t_clear_e1();
    set_cfg(0, 0); level_good();
    run(10, 0);
    run(31, 4);
    chk("R4 E1 window not yet complete", los, 1'b1);
    run(1, 0);
    chk("R4 E1 clears on 32nd interval", los, 1'b0);
  endtask

  task automatic t_declare_e1();
    level_lost();
    run(31, 0);
    chk("R2 E1 std 31 quiet", los, 1'b0);
    @(negedge clk); bit_stb = 1; pulse_in = 0;
    @(negedge clk); bit_stb = 0;
    chk("R2 E1 std 32 quiet", los, 1'b1);
    chk("R8 irq with rise", los_irq, 1'b1);
    @(negedge clk);
    chk("R8 irq one cycle", los_irq, 1'b0);
  endtask

  task automatic t_mask();
    go_clear_e1();
    irq_mask = 1'b1; level_lost();
    @(negedge clk);
    for (int i = 0; i < 32; i++) begin
      bit_stb = 1; pulse_in = 0;
      @(negedge clk);
    end
    bit_stb = 0;
    chk("R8 masked los", los, 1'b1);
    chk("R8 masked irq", los_irq, 1'b0);
    irq_mask = 1'b0;
  endtask

  task automatic t_qualify();
    go_clear_e1();
    level_lost();
    run(20, 0); run(1, 1); run(20, 0);
    chk("R3 pulse restarts count", los, 1'b0);
    lvl_below_decl = 1'b0;
    run(40, 0);
    chk("R3 level not below", los, 1'b0);
    lvl_below_decl = 1'b1;
    repeat (40) @(negedge clk);
    chk("R3 no strobe ignored", los, 1'b0);
    run(32, 0);
    chk("R3 declares after requalify", los, 1'b1);
  endtask

  task automatic t_density_e1();
    level_good();
    run(30, 10); run(2, 0);
    chk("R5 E1 3 marks fails", los, 1'b1);
    run(32, 8);
    chk("R5 E1 4 marks clears", los, 1'b0);
  endtask

  task automatic t_zeros_e1();
    level_lost(); run(32, 0);
    level_good();
    run(1, 1); run(16, 0); run(15, 4);
    chk("R6 E1 16 zeros fails", los, 1'b1);
    run(1, 1); run(15, 0); run(16, 4);
    chk("R6 E1 15 zeros allowed", los, 1'b0);
  endtask

  task automatic t_level_drop();
    level_lost(); run(32, 0);
    level_good();
    run(10, 2);
    lvl_above_clr = 1'b0;
    run(1, 0);
    lvl_above_clr = 1'b1;
    run(21, 2);
    chk("R7 level drop fails window", los, 1'b1);
    run(32, 2);
    chk("R7 later window clears", los, 1'b0);
  endtask

  task automatic t_t1();
    set_cfg(1, 0);
    level_lost();
    run(174, 0);
    chk("R2 T1 std 174 quiet", los, 1'b0);
    run(1, 0);
    chk("R2 T1 std 175 quiet", los, 1'b1);
    level_good();
    run(120, 8); run(8, 0);
    chk("R5 T1 15 marks fails", los, 1'b1);
    run(127, 8);
    chk("R4 T1 window not complete", los, 1'b1);
    run(1, 0);
    chk("R5 T1 16 marks clears", los, 1'b0);
    level_lost(); run(175, 0);
    level_good();
    run(1, 1); run(100, 0); run(27, 1);
    chk("R6 T1 100 zeros fails", los, 1'b1);
    run(1, 1); run(99, 0); run(28, 1);
    chk("R6 T1 99 zeros allowed", los, 1'b0);
  endtask

  task automatic t_long_windows();
    set_cfg(1, 1); level_lost();
    run(1543, 0);
    chk("R2 T1 alt 1543 quiet", los, 1'b0);
    run(1, 0);
    chk("R2 T1 alt 1544 quiet", los, 1'b1);
    go_clear_e1();
    set_cfg(0, 1); level_lost();
    run(2047, 0);
    chk("R2 E1 alt 2047 quiet", los, 1'b0);
    run(1, 0);
    chk("R2 E1 alt 2048 quiet", los, 1'b1);
  endtask

  task automatic t_cfg_change();
    go_clear_e1();
    level_lost();
    run(20, 0);
    set_cfg(0, 1); set_cfg(0, 0);
    chk("R10 los kept while clear", los, 1'b0);
    run(20, 0);
    chk("R10 count restarted", los, 1'b0);
    run(12, 0);
    chk("R10 declares after full N", los, 1'b1);
    level_good();
    run(20, 4);
    set_cfg(0, 1); set_cfg(0, 0);
    chk("R10 los kept while set", los, 1'b1);
    run(12, 4);
    chk("R10 window closed", los, 1'b1);
    run(32, 4);
    chk("R10 fresh window clears", los, 1'b0);
  endtask

  task automatic t_ais();
    level_lost(); run(32, 0);
    rx_ais_en = 1; line_ais_en = 0;
    #1;
    chk("R9 rx force", rx_force_ones, 1'b1);
    chk("R9 rx clk sel", rx_clk_sel_mclk, 1'b1);
    chk("R9 tx off", tx_force_ones, 1'b0);
    rx_ais_en = 0; line_ais_en = 1;
    #1;
    chk("R9 rx off", rx_force_ones, 1'b0);
    chk("R9 tx force", tx_force_ones, 1'b1);
    rx_ais_en = 1;
    go_clear_e1();
    chk("R9 no force when clear rx", rx_force_ones, 1'b0);
    chk("R9 no force when clear tx", tx_force_ones, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_clear_e1();
    t_declare_e1();
    t_mask();
    t_qualify();
    t_density_e1();
    t_zeros_e1();
    t_level_drop();
    t_t1();
    t_long_windows();
    t_cfg_change();
    t_ais();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule